// File: doc/BRIEF.md
# Message-Signalled Interrupt Collector

This block gathers eleven interrupt lines coming from a bus bridge and turns them into one processor interrupt. Each line passes through a synchroniser. Any change of a line, rising or falling, is latched into two read-to-clear registers:

- The pending register records changes on every line.
- The request register records changes only on lines that the mask enables and that are implemented.

A register that shows the live line levels lets software see which lines are still asserted. Software can then emulate level-triggered sharing on top of the change-triggered latching.

The block does not drive a processor wire. It signals the processor by posting one outbound write on a valid/ready channel. The address and the data word of that write both come from a single target register. The low bits of the target give the data and the remaining bits give the address. New requests that arrive while a write is still outstanding are merged into the request register. They do not queue further writes. A control bit can hold delivery back while requests keep latching.

Top module: `irq_msg_ctrl`

## Requirements
- R1: After reset the mask, request, pending and control registers read zero, `reg_rdata` is zero and `msg_valid` is low.
- R2: The live register at offset 0x028 shows the synchronised line levels two rising edges after a line changes. Its value does not depend on the mask or on reads of other registers.
- R3: A rise or a fall on an enabled, implemented line sets its bit in the request register at offset 0x00C on the third rising edge after the change. The line numbering is: bits 0 to 5 are the shared PCI lines A to F, bit 6 is the external bus line, and bit 10 is the serial-port line.
- R4: A change on a line whose mask bit is clear never sets a request bit. A line that is already high when its mask bit is set produces no request by itself.
- R5: A read of offset 0x00C returns the request bits on `reg_rdata` after that edge and clears them. A request bit set on the same edge as the read is kept.
- R6: Only bits set in the implemented mask 0x5FF can latch a request. Bit 9 never appears in the request register or posts a write, while bit 8 and bit 10 do.
- R7: The pending register at offset 0x01C latches a change on every line, masked or not. A read of it returns the pending bits and clears them, and leaves the live register unchanged.
- R8: On the edge where a new request bit is set, `msg_valid` rises with two values:
  - `msg_addr`: the target register with its low 8 bits cleared.
  - `msg_data`: the low 8 bits of the target register.
  `msg_valid`, `msg_addr` and `msg_data` then hold steady until `msg_ready` is seen high.
- R9: Requests that arrive while a write is outstanding are merged into the request register. A write that completes is followed by no extra write unless a later change occurs.
- R10: While control bit 0 (offset 0x024) is set, no write is started, but request bits still latch.
- R11: These registers can be written and read back on `reg_rdata` after the read edge:
  - the 32-bit target register at offset 0x004;
  - the mask register at offset 0x018, bits 10:0;
  - control bit 0 at offset 0x024.
  `reg_rdata` holds its value when no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 11 | Asynchronous interrupt lines from the bridge |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects apply on this edge) |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, registered on the read edge |
| msg_valid | output | 1 | Outbound interrupt write is pending |
| msg_ready | input | 1 | Outbound channel accepts the write |
| msg_addr | output | 32 | Destination address of the outbound write |
| msg_data | output | 32 | Data word of the outbound write |

## Verification
A line driven at a falling edge shows in the live register after two rising edges. It sets its request and pending bits, and can raise `msg_valid`, on the third rising edge. Read data and read-clear effects appear on the rising edge that samples the strobe. A behavioural model in the bench advances on every rising edge and is compared with all outputs at every falling edge. Directed steps wait four cycles after each line change and then check fixed expected values. One step times a read strobe to land exactly on the third edge after a change, to show that the new request survives the clear.

// File: rtl/irq_msg_pkg.sv
package irq_msg_pkg;
   localparam int REG_AW = 12;

   localparam logic [REG_AW-1:0] OFS_TARGET = 12'h004;
   localparam logic [REG_AW-1:0] OFS_REQ    = 12'h00C;
   localparam logic [REG_AW-1:0] OFS_MASK   = 12'h018;
   localparam logic [REG_AW-1:0] OFS_PEND   = 12'h01C;
   localparam logic [REG_AW-1:0] OFS_CTRL   = 12'h024;
   localparam logic [REG_AW-1:0] OFS_LIVE   = 12'h028;

   typedef enum logic [2:0] {
      SEL_NONE, SEL_TARGET, SEL_REQ, SEL_MASK, SEL_PEND, SEL_CTRL, SEL_LIVE
   } reg_sel_e;

   function automatic reg_sel_e decode_ofs(input logic [REG_AW-1:0] a);
      case (a)
         OFS_TARGET: return SEL_TARGET;
         OFS_REQ:    return SEL_REQ;
         OFS_MASK:   return SEL_MASK;
         OFS_PEND:   return SEL_PEND;
         OFS_CTRL:   return SEL_CTRL;
         OFS_LIVE:   return SEL_LIVE;
         default:    return SEL_NONE;
      endcase
   endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
   parameter int WIDTH  = 11,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("irq_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg[s] <= '0;
      end else begin
         stg[0] <= d;
         for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/irq_change_latch.sv
module irq_change_latch #(
   parameter int               WIDTH     = 11,
   parameter logic [WIDTH-1:0] IMPL_MASK = 11'h5FF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] lvl,
   input  logic [WIDTH-1:0] mask,
   input  logic             clr_req,
   input  logic             clr_pend,
   output logic [WIDTH-1:0] req_q,
   output logic [WIDTH-1:0] pend_q,
   output logic             new_evt
);
   logic [WIDTH-1:0] prev_q;
   logic [WIDTH-1:0] chg;
   logic [WIDTH-1:0] req_set;

   assign chg     = lvl ^ prev_q;
   assign req_set = chg & mask & IMPL_MASK;
   assign new_evt = |req_set;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         req_q  <= '0;
         pend_q <= '0;
      end else begin
         prev_q <= lvl;
         req_q  <= (clr_req  ? '0 : req_q)  | req_set;
         pend_q <= (clr_pend ? '0 : pend_q) | chg;
      end
   end

   AST_REQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (req_q & ~$past(req_q) & ~$past(mask)) == '0);   // R4
   AST_REQ_RD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clr_req |=> (req_q & ~$past(req_set)) == '0);    // R5
   AST_UNIMPL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (req_q & ~IMPL_MASK) == '0);                      // R6
   AST_PEND_RD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clr_pend |=> (pend_q & ~$past(chg)) == '0);       // R7
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
   import irq_msg_pkg::*;
#(
   parameter int WIDTH = 11,
   parameter int REG_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   input  logic [WIDTH-1:0]  req_q,
   input  logic [WIDTH-1:0]  pend_q,
   input  logic [WIDTH-1:0]  live,
   output logic [REG_W-1:0]  reg_rdata,
   output logic [WIDTH-1:0]  mask_q,
   output logic [REG_W-1:0]  target_q,
   output logic              hold_q,
   output logic              clr_req,
   output logic              clr_pend
);
   reg_sel_e         sel;
   logic [REG_W-1:0] rd_mux;

   assign sel      = decode_ofs(reg_addr);
   assign clr_req  = reg_rd && (sel == SEL_REQ);
   assign clr_pend = reg_rd && (sel == SEL_PEND);

   always_comb begin
      case (sel)
         SEL_TARGET: rd_mux = target_q;
         SEL_REQ:    rd_mux = REG_W'(req_q);
         SEL_MASK:   rd_mux = REG_W'(mask_q);
         SEL_PEND:   rd_mux = REG_W'(pend_q);
         SEL_CTRL:   rd_mux = REG_W'(hold_q);
         SEL_LIVE:   rd_mux = REG_W'(live);
         default:    rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q    <= '0;
         target_q  <= '0;
         hold_q    <= 1'b0;
         reg_rdata <= '0;
      end else begin
         if (reg_rd) reg_rdata <= rd_mux;
         if (reg_wr) begin
            case (sel)
               SEL_TARGET: target_q <= reg_wdata;
               SEL_MASK:   mask_q   <= reg_wdata[WIDTH-1:0];
               SEL_CTRL:   hold_q   <= reg_wdata[0];
               default:    ;
            endcase
         end
      end
   end

   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd |=> $stable(reg_rdata));                  // R11
endmodule

// File: rtl/irq_msg_post.sv
module irq_msg_post #(
   parameter int REG_W    = 32,
   parameter int DFIELD_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire,
   input  logic             hold,
   input  logic [REG_W-1:0] target,
   output logic             msg_valid,
   input  logic             msg_ready,
   output logic [REG_W-1:0] msg_addr,
   output logic [REG_W-1:0] msg_data
);
   localparam logic [REG_W-1:0] DMASK = {{(REG_W-DFIELD_W){1'b0}}, {DFIELD_W{1'b1}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         msg_valid <= 1'b0;
         msg_addr  <= '0;
         msg_data  <= '0;
      end else if (!msg_valid) begin
         if (fire && !hold) begin
            msg_valid <= 1'b1;
            msg_addr  <= target & ~DMASK;
            msg_data  <= target & DMASK;
         end
      end else if (msg_ready) begin
         msg_valid <= 1'b0;
      end
   end

   AST_VALID_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data)); // R8
   AST_NO_REFIRE: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid && msg_ready |=> !msg_valid);                                          // R9
   AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      hold && !msg_valid |=> !msg_valid);                                              // R10
endmodule

// File: rtl/irq_msg_ctrl.sv
module irq_msg_ctrl
   import irq_msg_pkg::*;
#(
   parameter int                   NUM_LINES   = 11,
   parameter logic [NUM_LINES-1:0] IMPL_MASK   = 11'h5FF,
   parameter int                   REG_W       = 32,
   parameter int                   DFIELD_W    = 8,
   parameter int                   SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_lines,
   input  logic                 reg_wr,
   input  logic                 reg_rd,
   input  logic [REG_AW-1:0]    reg_addr,
   input  logic [REG_W-1:0]     reg_wdata,
   output logic [REG_W-1:0]     reg_rdata,
   output logic                 msg_valid,
   input  logic                 msg_ready,
   output logic [REG_W-1:0]     msg_addr,
   output logic [REG_W-1:0]     msg_data
);
   generate
      if (NUM_LINES > REG_W) begin : g_bad_lines
         $error("irq_msg_ctrl: NUM_LINES exceeds REG_W");
      end
      if (DFIELD_W < 1 || DFIELD_W >= REG_W) begin : g_bad_dfield
         $error("irq_msg_ctrl: DFIELD_W out of range");
      end
   endgenerate

   logic [NUM_LINES-1:0] live, mask_q, req_q, pend_q;
   logic [REG_W-1:0]     target_q;
   logic                 hold_q, clr_req, clr_pend, new_evt;

   irq_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(irq_lines), .q(live));

   irq_change_latch #(.WIDTH(NUM_LINES), .IMPL_MASK(IMPL_MASK)) u_latch (
      .clk(clk), .rst_n(rst_n), .lvl(live), .mask(mask_q),
      .clr_req(clr_req), .clr_pend(clr_pend),
      .req_q(req_q), .pend_q(pend_q), .new_evt(new_evt));

   irq_regfile #(.WIDTH(NUM_LINES), .REG_W(REG_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .req_q(req_q), .pend_q(pend_q), .live(live),
      .reg_rdata(reg_rdata), .mask_q(mask_q), .target_q(target_q),
      .hold_q(hold_q), .clr_req(clr_req), .clr_pend(clr_pend));

   irq_msg_post #(.REG_W(REG_W), .DFIELD_W(DFIELD_W)) u_post (
      .clk(clk), .rst_n(rst_n), .fire(new_evt), .hold(hold_q),
      .target(target_q), .msg_valid(msg_valid), .msg_ready(msg_ready),
      .msg_addr(msg_addr), .msg_data(msg_data));
endmodule

// File: tb/sim_irq_msg_ctrl.sv
`timescale 1ns/1ps
module sim_irq_msg_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [10:0] irq_lines = '0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0, msg_ready = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata, msg_addr, msg_data;
   logic        msg_valid;

   always #2.5 clk = ~clk;

   irq_msg_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .msg_valid(msg_valid), .msg_ready(msg_ready),
      .msg_addr(msg_addr), .msg_data(msg_data));

   int vectors = 0, miscompares = 0, handshakes = 0, cyc = 0;
   bit running = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // behavioural reference: input history queue and register images
   logic [10:0] hist[$];
   logic [10:0] m_prev, m_req, m_pend, m_mask;
   logic [31:0] m_tgt, m_rd, m_a, m_d;
   logic        m_ctrl, m_v;
   string       m_tag = "R1 rdata";

   always @(posedge clk) begin
      if (!rst_n) begin
         hist = {11'd0, 11'd0};
         m_prev = '0; m_req = '0; m_pend = '0; m_mask = '0;
         m_tgt = '0; m_rd = '0; m_a = '0; m_d = '0; m_ctrl = 1'b0; m_v = 1'b0;
      end else begin
         logic [10:0] lv, chg, rset;
         logic        fire, nv;
         lv   = hist[1];
         chg  = lv ^ m_prev;
         rset = chg & m_mask & 11'h5FF;
         fire = (rset != 0);
         if (msg_valid && msg_ready) handshakes++;
         if (reg_rd) begin
            case (reg_addr)
               12'h004: begin m_rd = m_tgt;          m_tag = "R11 target"; end
               12'h00C: begin m_rd = {21'd0, m_req};  m_tag = "R5 request"; end
               12'h018: begin m_rd = {21'd0, m_mask}; m_tag = "R11 mask"; end
               12'h01C: begin m_rd = {21'd0, m_pend}; m_tag = "R7 pending"; end
               12'h024: begin m_rd = {31'd0, m_ctrl}; m_tag = "R10 control"; end
               12'h028: begin m_rd = {21'd0, lv};     m_tag = "R2 live"; end
               default: begin m_rd = '0;              m_tag = "R11 unmapped"; end
            endcase
         end
         nv = m_v;
         if (m_v && msg_ready) nv = 1'b0;
         if (!m_v && fire && !m_ctrl) begin
            nv = 1'b1;
            m_a = m_tgt & 32'hFFFF_FF00;
            m_d = m_tgt & 32'h0000_00FF;
         end
         m_v = nv;
         m_req  = ((reg_rd && reg_addr == 12'h00C) ? 11'd0 : m_req)  | rset;
         m_pend = ((reg_rd && reg_addr == 12'h01C) ? 11'd0 : m_pend) | chg;
         if (reg_wr) begin
            if (reg_addr == 12'h004) m_tgt  = reg_wdata;
            if (reg_addr == 12'h018) m_mask = reg_wdata[10:0];
            if (reg_addr == 12'h024) m_ctrl = reg_wdata[0];
         end
         m_prev = lv;
         hist.push_front(irq_lines);
         void'(hist.pop_back());
      end
   end

   always @(negedge clk) begin
      if (running) begin
         chk(m_tag, reg_rdata, m_rd);
         chk("R8 msg_valid", {31'd0, msg_valid}, {31'd0, m_v});
         if (m_v) begin
            chk("R8 msg_addr", msg_addr, m_a);
            chk("R8 msg_data", msg_data, m_d);
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         miscompares++;
         $display("FAIL watchdog expired actual=%0d expected<=100000", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask
   task automatic do_write(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0;
   endtask
   task automatic do_read(input logic [11:0] a);
      @(negedge clk); reg_rd = 1'b1; reg_addr = a;
      @(negedge clk); reg_rd = 1'b0;
   endtask
   task automatic set_line(input int i, input logic v);
      @(negedge clk); irq_lines[i] = v;
   endtask
   task automatic pulse_ready();
      @(negedge clk); msg_ready = 1'b1;
      @(negedge clk); msg_ready = 1'b0;
   endtask

   initial begin
      wait_cyc(3);
      rst_n = 1'b1;
      running = 1'b1;
      wait_cyc(1);
      // R1 reset state
      chk("R1 msg_valid", {31'd0, msg_valid}, 32'd0);
      chk("R1 rdata", reg_rdata, 32'd0);
      do_read(12'h018); chk("R1 mask", reg_rdata, 32'd0);
      do_read(12'h00C); chk("R1 request", reg_rdata, 32'd0);
      do_read(12'h01C); chk("R1 pending", reg_rdata, 32'd0);
      do_read(12'h024); chk("R1 control", reg_rdata, 32'd0);

      // R8 single write on an enabled change
      do_write(12'h004, 32'hFFFE_1005);
      do_write(12'h018, 32'h0000_0001);
      set_line(0, 1'b1); wait_cyc(4);
      chk("R3 R8 valid after INTA rise", {31'd0, msg_valid}, 32'd1);
      chk("R8 addr", msg_addr, 32'hFFFE_1000);
      chk("R8 data", msg_data, 32'h0000_0005);
      wait_cyc(3);
      chk("R8 held without ready", {31'd0, msg_valid}, 32'd1);
      // R9 merge while outstanding
      @(negedge clk); irq_lines[0] = 1'b0; irq_lines[1] = 1'b1;
      wait_cyc(4);
      pulse_ready();
      chk("R9 valid drops after handshake", {31'd0, msg_valid}, 32'd0);
      wait_cyc(4);
      chk("R9 no extra write", {31'd0, msg_valid}, 32'd0);
      chk("R9 handshake count", handshakes, 32'd1);
      do_read(12'h00C); chk("R5 R3 request bit0", reg_rdata, 32'h001);
      do_read(12'h00C); chk("R5 cleared after read", reg_rdata, 32'h000);
      // R7 pending and R2 live
      do_read(12'h01C); chk("R7 pending masked+unmasked", reg_rdata, 32'h003);
      do_read(12'h028); chk("R2 live levels", reg_rdata, 32'h002);
      do_read(12'h01C); chk("R7 pending cleared", reg_rdata, 32'h000);
      do_read(12'h028); chk("R7 live untouched by pending read", reg_rdata, 32'h002);

      // R4 asserted line at unmask
      set_line(2, 1'b1); wait_cyc(4);
      do_read(12'h01C); chk("R7 pending line2", reg_rdata, 32'h004);
      do_write(12'h018, 32'h0000_0005); wait_cyc(4);
      chk("R4 no write on unmask", {31'd0, msg_valid}, 32'd0);
      do_read(12'h00C); chk("R4 no request on unmask", reg_rdata, 32'h000);

      // R6 implemented mask
      do_write(12'h018, 32'h0000_07FF);
      set_line(9, 1'b1); wait_cyc(4);
      chk("R6 bit9 posts nothing", {31'd0, msg_valid}, 32'd0);
      do_read(12'h00C); chk("R6 bit9 not latched", reg_rdata, 32'h000);
      set_line(8, 1'b1); wait_cyc(4);
      chk("R6 bit8 posts", {31'd0, msg_valid}, 32'd1);
      do_read(12'h00C); chk("R6 bit8 latched", reg_rdata, 32'h100);
      pulse_ready();
      set_line(10, 1'b1); wait_cyc(4);
      chk("R3 serial line posts", {31'd0, msg_valid}, 32'd1);
      do_read(12'h00C); chk("R3 serial bit10", reg_rdata, 32'h400);
      pulse_ready();

      // R10 hold and R11 readback
      do_write(12'h024, 32'h0000_0001);
      do_read(12'h024); chk("R11 control readback", reg_rdata, 32'h1);
      do_read(12'h004); chk("R11 target readback", reg_rdata, 32'hFFFE_1005);
      do_read(12'h018); chk("R11 mask readback", reg_rdata, 32'h7FF);
      do_write(12'h00C, 32'hFFFF_FFFF);
      do_read(12'h00C); chk("R11 write to request ignored", reg_rdata, 32'h000);
      set_line(0, 1'b1); wait_cyc(4);
      chk("R10 hold blocks write", {31'd0, msg_valid}, 32'd0);
      do_read(12'h00C); chk("R10 request still latched", reg_rdata, 32'h001);
      do_write(12'h024, 32'h0); wait_cyc(3);
      chk("R10 no retro write", {31'd0, msg_valid}, 32'd0);

      // R5 change coinciding with clearing read
      @(negedge clk); irq_lines[3] = 1'b1;
      @(negedge clk);
      @(negedge clk); reg_rd = 1'b1; reg_addr = 12'h00C;
      @(negedge clk); reg_rd = 1'b0;
      chk("R5 coincident read returns old", reg_rdata, 32'h000);
      do_read(12'h00C); chk("R5 coincident request kept", reg_rdata, 32'h008);
      pulse_ready();

      // random traffic checked against the model each cycle
      for (int k = 0; k < 600; k++) begin
         @(negedge clk);
         if ($urandom_range(0, 3) == 0) irq_lines[$urandom_range(0, 10)] ^= 1'b1;
         msg_ready = ($urandom_range(0, 2) == 0);
         reg_rd = ($urandom_range(0, 3) == 0);
         reg_wr = ($urandom_range(0, 15) == 0);
         case ($urandom_range(0, 4))
            0: reg_addr = 12'h00C;
            1: reg_addr = 12'h01C;
            2: reg_addr = 12'h028;
            3: reg_addr = 12'h018;
            default: reg_addr = 12'h024;
         endcase
         reg_wdata = (reg_addr == 12'h024) ? {31'd0, ($urandom_range(0, 3) == 0)} : $urandom;
      end
      @(negedge clk); reg_rd = 1'b0; reg_wr = 1'b0; msg_ready = 1'b0;
      wait_cyc(4);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule